// File: doc/BRIEF.md
# Two-Level Transpose-Linked Prefix-Sum Unit

This block computes the running (inclusive prefix) sum of n⁴ operands loaded in parallel. The operands are organised as n² groups of n×n cells. Operand p goes to the cell whose row-major position inside its group, followed by the group's row-major position among the groups, gives p. Every group first forms its own inclusive prefix with a row-scan / column-scan structure. The total held by the last cell of each group is then carried to one collector group (the last group) by a fixed transpose permutation. In that permutation cell (k,l) of group (i,j) trades places with cell (i,j) of group (k,l). The collector forms an exclusive prefix over those totals. A second pass through the same permutation sends each group its offset. The offset is then spread across the group and added to the local prefix.

The unit is driven by a one-cycle start and a flat operand vector. It answers with a flat result vector and a single-cycle done pulse. Each stage takes one clock, and both transpose moves take one clock each. Arithmetic is modulo 2^W.

Top module: `xpose_prefix_unit`

## Requirements
- R1: After synchronous active-low reset, `done` is 0 and every slot of `result` is 0.
- R2: Operand slot p is `operands[p*W +: W]`. After a run, result slot p (`result[p*W +: W]`) equals the sum of operand slots 0 through p.
- R3: All sums wrap modulo 2^W. With every operand at 2^W−1, slot p holds 2^W−(p+1).
- R4: The `start` sample is taken on a rising edge while the unit is idle. `done` goes high after the seventh rising edge counted from that edge and stays high for exactly one cycle.
- R5: `result` keeps its value between runs. Changing `operands` while idle has no effect on it.
- R6: While a run is in progress, `start` and `operands` are ignored. The result is that of the operands captured at the start, and no second run follows.
- R7: An operand in any group reaches every later group through the two transpose moves. A single nonzero operand at slot p yields zero in slots below p and that operand's value in slot p and every slot above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| operands | input | SIDE⁴·W | Flat operand vector, slot p at bits p·W upward |
| done | output | 1 | One-cycle completion pulse |
| result | output | SIDE⁴·W | Flat inclusive prefix vector, held between runs |

## Verification
Impulse runs place one nonzero operand at each slot in turn. A wrong transpose index, or a collector reading the wrong cell, would show up as a step appearing in the wrong group or not at all. All-ones operands check the wrap: a design that kept carries or widened its sums would give values that do not descend from 0xFFFF. A restart pulse in the middle of a run, with new operands, catches a design that re-captures its inputs or runs twice. Runs checked for exact latency and pulse width catch a stage that was skipped or repeated.

// File: rtl/xpose_prefix_pkg.sv
// Shared types and index helpers for the transpose-linked prefix unit.
// Assumes cells are numbered row-major inside a group, groups row-major.
package xpose_prefix_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOCAL   = 3'd1,
        ST_GATHER  = 3'd2,
        ST_COLLECT = 3'd3,
        ST_RETURN  = 3'd4,
        ST_SPREAD  = 3'd5,
        ST_SUM     = 3'd6
    } stage_e;

    // Flat cell index of (group row, group col, cell row, cell col), zero-based.
    function automatic int cell_idx(input int gr, input int gc,
                                    input int cr, input int cc, input int side);
        return ((gr * side + gc) * side + cr) * side + cc;
    endfunction

endpackage

// File: rtl/xpose_line_scan.sv
// Scans one line of LEN values: gives inclusive and exclusive running sums
// and the line total. Purely combinational; sums wrap modulo 2^W.
module xpose_line_scan #(
    parameter int LEN = 2,
    parameter int W   = 16
) (
    input  logic [LEN-1:0][W-1:0] din,
    output logic [LEN-1:0][W-1:0] incl,
    output logic [LEN-1:0][W-1:0] excl,
    output logic [W-1:0]          total
);
    // Running accumulation along the line.
    always_comb begin
        logic [W-1:0] acc;
        acc = '0;
        for (int e = 0; e < LEN; e++) begin
            excl[e] = acc;
            acc     = acc + din[e];
            incl[e] = acc;
        end
        total = acc;
    end
endmodule

// File: rtl/xpose_group_scan.sv
// Prefix over one SIDE x SIDE group in row-major order: row scans, a column
// scan of row totals, then an add. EXCL=1 yields the exclusive variant.
module xpose_group_scan #(
    parameter int SIDE = 2,
    parameter int W    = 16,
    parameter bit EXCL = 1'b0
) (
    input  logic [SIDE*SIDE-1:0][W-1:0] din,
    output logic [SIDE*SIDE-1:0][W-1:0] dout
);
    logic [SIDE-1:0][W-1:0] row_tot;
    logic [SIDE-1:0][W-1:0] row_off_incl;
    logic [SIDE-1:0][W-1:0] row_off_excl;
    logic [W-1:0]           grp_tot;

    genvar r;
    generate
        for (r = 0; r < SIDE; r++) begin : g_row
            logic [SIDE-1:0][W-1:0] line_in;
            logic [SIDE-1:0][W-1:0] line_incl;
            logic [SIDE-1:0][W-1:0] line_excl;
            // Gather this row's cells.
            always_comb begin
                for (int c = 0; c < SIDE; c++) line_in[c] = din[r*SIDE + c];
            end
            xpose_line_scan #(.LEN(SIDE), .W(W)) u_row (
                .din(line_in), .incl(line_incl), .excl(line_excl),
                .total(row_tot[r])
            );
            // Combine row-local prefix with the offset of earlier rows.
            always_comb begin
                for (int c = 0; c < SIDE; c++)
                    dout[r*SIDE + c] = row_off_excl[r] +
                                       (EXCL ? line_excl[c] : line_incl[c]);
            end
        end
    endgenerate

    xpose_line_scan #(.LEN(SIDE), .W(W)) u_col (
        .din(row_tot), .incl(row_off_incl), .excl(row_off_excl),
        .total(grp_tot)
    );
endmodule

// File: rtl/xpose_transpose.sv
// Fixed transpose link: cell (cr,cc) of group (gr,gc) lands in cell (gr,gc)
// of group (cr,cc). One-cycle move is made by the caller's register.
module xpose_transpose #(
    parameter int SIDE = 2,
    parameter int W    = 16
) (
    input  logic [SIDE**4-1:0][W-1:0] src,
    output logic [SIDE**4-1:0][W-1:0] dst
);
    import xpose_prefix_pkg::*;
    genvar gr, gc, cr, cc;
    generate
        for (gr = 0; gr < SIDE; gr++) begin : g_gr
            for (gc = 0; gc < SIDE; gc++) begin : g_gc
                for (cr = 0; cr < SIDE; cr++) begin : g_cr
                    for (cc = 0; cc < SIDE; cc++) begin : g_cc
                        assign dst[cell_idx(cr, cc, gr, gc, SIDE)] =
                               src[cell_idx(gr, gc, cr, cc, SIDE)];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/xpose_prefix_unit.sv
// Two-level prefix-sum unit over SIDE^4 operands held as SIDE^2 groups.
// Stages: capture, local scan, gather (transpose), collector exclusive scan,
// return (transpose), spread, add. One stage per clock; start ignored when busy.
module xpose_prefix_unit #(
    parameter int SIDE = 2,
    parameter int W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SIDE**4*W-1:0]   operands,
    output logic                   done,
    output logic [SIDE**4*W-1:0]   result
);
    import xpose_prefix_pkg::*;

    localparam int GROUPS = SIDE * SIDE;
    localparam int CELLS  = GROUPS * GROUPS;
    localparam int COLL   = GROUPS - 1;   // collector group = last group
    localparam int LASTC  = GROUPS - 1;   // last cell inside a group

    stage_e                    stage_q;
    logic [CELLS-1:0][W-1:0]   a_q;
    logic [CELLS-1:0][W-1:0]   b_q;
    logic [CELLS-1:0][W-1:0]   res_q;
    logic                      done_q;

    logic [CELLS-1:0][W-1:0]   local_pfx;
    logic [CELLS-1:0][W-1:0]   xp_in;
    logic [CELLS-1:0][W-1:0]   xp_out;
    logic [GROUPS-1:0][W-1:0]  coll_in;
    logic [GROUPS-1:0][W-1:0]  coll_out;

    // Local inclusive scan in every group.
    genvar g;
    generate
        for (g = 0; g < GROUPS; g++) begin : g_grp
            logic [GROUPS-1:0][W-1:0] gin;
            logic [GROUPS-1:0][W-1:0] gout;
            // Slice this group's cells out of the A bank.
            always_comb begin
                for (int c = 0; c < GROUPS; c++) gin[c] = a_q[g*GROUPS + c];
            end
            xpose_group_scan #(.SIDE(SIDE), .W(W), .EXCL(1'b0)) u_scan (
                .din(gin), .dout(gout)
            );
            // Place local prefixes back at flat positions.
            always_comb begin
                for (int c = 0; c < GROUPS; c++) local_pfx[g*GROUPS + c] = gout[c];
            end
        end
    endgenerate

    // Collector cells feed the exclusive scan.
    always_comb begin
        for (int c = 0; c < GROUPS; c++) coll_in[c] = a_q[COLL*GROUPS + c];
    end

    xpose_group_scan #(.SIDE(SIDE), .W(W), .EXCL(1'b1)) u_coll (
        .din(coll_in), .dout(coll_out)
    );

    // One shared transpose: B bank on gather, A bank on return.
    assign xp_in = (stage_q == ST_GATHER) ? b_q : a_q;

    xpose_transpose #(.SIDE(SIDE), .W(W)) u_xp (
        .src(xp_in), .dst(xp_out)
    );

    // Stage sequencer and data banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
            a_q     <= '0;
            b_q     <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (stage_q)
                ST_IDLE: begin
                    if (start) begin
                        for (int p = 0; p < CELLS; p++) a_q[p] <= operands[p*W +: W];
                        stage_q <= ST_LOCAL;
                    end
                end
                ST_LOCAL: begin
                    b_q     <= local_pfx;
                    stage_q <= ST_GATHER;
                end
                ST_GATHER: begin
                    a_q     <= xp_out;
                    stage_q <= ST_COLLECT;
                end
                ST_COLLECT: begin
                    for (int c = 0; c < GROUPS; c++) a_q[COLL*GROUPS + c] <= coll_out[c];
                    stage_q <= ST_RETURN;
                end
                ST_RETURN: begin
                    a_q     <= xp_out;
                    stage_q <= ST_SPREAD;
                end
                ST_SPREAD: begin
                    for (int gg = 0; gg < GROUPS; gg++)
                        for (int c = 0; c < GROUPS; c++)
                            a_q[gg*GROUPS + c] <= a_q[gg*GROUPS + LASTC];
                    stage_q <= ST_SUM;
                end
                ST_SUM: begin
                    for (int p = 0; p < CELLS; p++) res_q[p] <= a_q[p] + b_q[p];
                    done_q  <= 1'b1;
                    stage_q <= ST_IDLE;
                end
                default: stage_q <= ST_IDLE;
            endcase
        end
    end

    // Flatten the result bank onto the port.
    always_comb begin
        for (int p = 0; p < CELLS; p++) result[p*W +: W] = res_q[p];
    end
    assign done = done_q;

    // Assertions next to the sequencer.
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                          // R4
    AST_SUM_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_SUM) |=> done_q);                              // R4
    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_IDLE && start) |=> (stage_q == ST_LOCAL));     // R4
    AST_BUSY_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != ST_IDLE && stage_q != ST_SUM) |=> (stage_q != ST_IDLE)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != ST_SUM) |=> $stable(res_q));                      // R5

    generate
        for (g = 0; g < GROUPS; g++) begin : g_chk
            AST_GATHER_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_q == ST_GATHER) |=>
                (a_q[COLL*GROUPS + g] == $past(b_q[g*GROUPS + LASTC])));  // R7
            AST_RETURN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
                (stage_q == ST_RETURN) |=>
                (a_q[g*GROUPS + LASTC] == $past(a_q[COLL*GROUPS + g])));  // R7
        end
    endgenerate
endmodule

// File: tb/sim_xpose_prefix_unit.sv
module sim_xpose_prefix_unit;
    localparam int SIDE  = 2;
    localparam int W     = 16;
    localparam int CELLS = SIDE**4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CELLS*W-1:0]   operands = '0;
    logic                 done;
    logic [CELLS*W-1:0]   result;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    xpose_prefix_unit #(.SIDE(SIDE), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operands(operands),
        .done(done), .result(result)
    );

    function automatic logic [CELLS*W-1:0] ref_prefix(input logic [CELLS*W-1:0] ops);
        logic [W-1:0] acc = '0;
        logic [CELLS*W-1:0] r;
        for (int p = 0; p < CELLS; p++) begin
            acc = acc + ops[p*W +: W];
            r[p*W +: W] = acc;
        end
        return r;
    endfunction

    task automatic check_vec(input string tag, input logic [CELLS*W-1:0] got,
                             input logic [CELLS*W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // Launch a run and wait for done; checks R4 latency and pulse width.
    // If mid_ops_en, pulses start with other operands during the run (R6).
    task automatic run(input logic [CELLS*W-1:0] ops, input bit mid_ops_en,
                       input logic [CELLS*W-1:0] mid_ops);
        int k;
        @(negedge clk);
        operands = ops;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 20) begin
            if (mid_ops_en && k == 3) begin
                start = 1'b1;
                operands = mid_ops;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        n_cmp++;
        if (k != 7) begin
            n_bad++;
            $display("FAIL R4 latency actual=%0d expected=7", k);
        end
        @(negedge clk);
        check_bit("R4 done width", done, 1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [CELLS*W-1:0] ops;
        logic [CELLS*W-1:0] exp;
        logic [CELLS*W-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1 done after reset", done, 1'b0);
        check_vec("R1 result after reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 directed: ascending values
        for (int p = 0; p < CELLS; p++) ops[p*W +: W] = W'(p + 1);
        run(ops, 1'b0, '0);
        check_vec("R2 ascending", result, ref_prefix(ops));

        // R3 wrap: all ones -> slot p = 2^W-(p+1)
        for (int p = 0; p < CELLS; p++) ops[p*W +: W] = '1;
        run(ops, 1'b0, '0);
        for (int p = 0; p < CELLS; p++) exp[p*W +: W] = W'(-(p + 1));
        check_vec("R3 all ones wrap", result, exp);

        // R7 impulse at every slot
        for (int p = 0; p < CELLS; p++) begin
            ops = '0;
            ops[p*W +: W] = W'(16'h1000 + p * 3 + 1);
            exp = '0;
            for (int q = p; q < CELLS; q++) exp[q*W +: W] = ops[p*W +: W];
            run(ops, 1'b0, '0);
            check_vec($sformatf("R7 impulse slot %0d", p), result, exp);
        end

        // R5 hold: change operands while idle
        held = result;
        for (int p = 0; p < CELLS; p++) operands[p*W +: W] = W'($urandom);
        repeat (6) @(negedge clk);
        check_vec("R5 result held", result, held);

        // R6 start and new operands mid-run are ignored
        for (int p = 0; p < CELLS; p++) ops[p*W +: W] = W'($urandom);
        for (int p = 0; p < CELLS; p++) exp[p*W +: W] = W'($urandom);
        run(ops, 1'b1, exp);
        check_vec("R6 mid-run start ignored", result, ref_prefix(ops));
        begin
            bit extra = 1'b0;
            for (int t = 0; t < 12; t++) begin
                if (done) extra = 1'b1;
                @(negedge clk);
            end
            check_bit("R6 no second run", extra, 1'b0);
        end

        // R2/R3 random runs, large values
        for (int r = 0; r < 24; r++) begin
            for (int p = 0; p < CELLS; p++) ops[p*W +: W] = W'($urandom);
            run(ops, 1'b0, '0);
            check_vec($sformatf("R2 random run %0d", r), result, ref_prefix(ops));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule